// File: doc/BRIEF.md
# Programmable-Ratio CIC Decimator

This block reduces the sample rate of one baseband channel (the I or the Q path) that comes out of a digital mixer. It is a three-stage cascaded integrator-comb filter. The decimation ratio can be chosen at run time, which lets a receiver follow symbol rates that vary over a wide range. Three integrators accumulate every accepted input sample. A sample counter marks every R-th accepted sample, and on that mark three first-difference comb stages produce one output sample. The output is scaled back down by the filter's gain of R cubed and then truncated to the output width.

The integrator and comb registers are sized for the largest ratio, so wrap-around in the integrators never corrupts a result. A new ratio value is taken over in one of two places: at a synchronous clear, or at a decimation boundary. When the ratio changes at a boundary, the filter drops all of its history and starts again from zero. Droop compensation and matched filtering belong to later stages and are not part of this block.

Top module: `cic_decimator`

## Requirements
- R1: Each cycle with `in_valid_i` high and `srst_i` low adds the signed input to the first integrator. Each later integrator adds the newly updated value of the stage before it. All integrators are ACC_W = IN_W + 3·log2(R_MAX) bits wide (52 by default) and wrap in two's complement.
- R2: With an active ratio R, the R-th accepted sample after the last boundary or clear is a boundary. `out_valid_o` is high for exactly one cycle, in the cycle after the clock edge that accepted that sample, and is low at all other times.
- R3: At a boundary, the third integrator's value after that sample passes through three comb stages. Each comb stage outputs its input minus its input at the previous boundary (differential delay 1). The comb delays start at zero after a clear.
- R4: The comb result is shifted right arithmetically by S = ceil(log2(R³)) bits, and the low OUT_W bits become `out_data_o`. Examples: R=3 gives S=5, R=5 gives S=7, R=4096 gives S=36. `out_data_o` holds its value between outputs.
- R5: The requested ratio `ratio_i` is clamped into [3, 4096]. A value of 0 to 2 acts as 3, and a value above 4096 acts as 4096.
- R6: At a boundary where the clamped `ratio_i` differs from the active ratio, no output is emitted. The new ratio becomes active, and every integrator, every comb delay and the counter are cleared. The sample at that boundary is dropped.
- R7: `srst_i` high at a clock edge loads the clamped `ratio_i` as the active ratio, clears all filter state and the counter, drives `out_valid_o` low, and overrides any sample presented in that cycle.
- R8: While `rst_ni` is low, `out_valid_o` and `out_data_o` are 0, all state is cleared, and the active ratio is 3.
- R9: A cycle with `in_valid_i` low changes neither the filter state nor the counter. A changed `ratio_i` in the middle of a decimation period has no effect before the next boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| srst_i | input | 1 | Synchronous clear; also loads the ratio |
| ratio_i | input | 13 | Requested decimation ratio (clamped to 3..4096) |
| in_valid_i | input | 1 | Input sample strobe |
| in_data_i | input | 16 | Signed input sample |
| out_valid_o | output | 1 | One-cycle strobe per decimated sample |
| out_data_o | output | 16 | Signed decimated, gain-normalized sample |

## Verification
The bench drives full-scale DC inputs of both signs at the largest ratio. A wrong shift value, or an accumulator that is too narrow, would then show up as an output that differs from +32767 or -32768. It programs ratios of 0, 2 and 5000 to test the clamp. At those values a missing clamp would produce strobes at the wrong spacing and a wrong scale. It changes the ratio in the middle of a period and also at a boundary. A design that applied the change too early, or kept stale integrator or comb history, would emit an extra sample or a wrong one. Gaps in the valid strobe and random data check that idle cycles leave the state alone; a design that counted them would move its boundaries.

// File: rtl/cic_pkg.sv
package cic_pkg;
  // smallest s with 2**s >= r**stages
  function automatic int unsigned gain_shift(input int unsigned r, input int unsigned stages);
    logic [63:0] g;
    int unsigned s;
    g = 64'd1;
    for (int i = 0; i < 8; i++)
      if (i < int'(stages)) g = g * 64'(r);
    s = 0;
    for (int b = 0; b < 63; b++)
      if ((64'd1 << b) < g) s = b + 1;
    return s;
  endfunction
endpackage

// File: rtl/cic_integrators.sv
module cic_integrators #(
  parameter int N_STAGES = 3,
  parameter int IN_W     = 16,
  parameter int ACC_W    = 52
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clr_i,
  input  logic                    en_i,
  input  logic signed [IN_W-1:0]  din_i,
  output logic [ACC_W-1:0]        dout_o
);
  logic [ACC_W-1:0] din_ext;
  logic [ACC_W-1:0] sum [N_STAGES];

  assign din_ext = {{(ACC_W-IN_W){din_i[IN_W-1]}}, din_i};

  for (genvar g = 0; g < N_STAGES; g++) begin : g_stage
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] prev;
    if (g == 0) begin : g_first
      assign prev = din_ext;
    end else begin : g_rest
      assign prev = sum[g-1];
    end
    assign sum[g] = acc_q + prev;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    acc_q <= '0;
      else if (clr_i) acc_q <= '0;
      else if (en_i)  acc_q <= sum[g];
    end
  end

  assign dout_o = sum[N_STAGES-1];

  assert_idle_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clr_i) |=> $stable(g_stage[0].acc_q));
endmodule

// File: rtl/cic_combs.sv
module cic_combs #(
  parameter int N_STAGES = 3,
  parameter int ACC_W    = 52
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [ACC_W-1:0] din_i,
  output logic [ACC_W-1:0] dout_o
);
  logic [ACC_W-1:0] diff [N_STAGES];

  for (genvar g = 0; g < N_STAGES; g++) begin : g_stage
    logic [ACC_W-1:0] dly_q;
    logic [ACC_W-1:0] stage_in;
    if (g == 0) begin : g_first
      assign stage_in = din_i;
    end else begin : g_rest
      assign stage_in = diff[g-1];
    end
    assign diff[g] = stage_in - dly_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    dly_q <= '0;
      else if (clr_i) dly_q <= '0;
      else if (en_i)  dly_q <= stage_in;
    end
  end

  assign dout_o = diff[N_STAGES-1];

  assert_comb_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clr_i) |=> $stable(g_stage[0].dly_q));
endmodule

// File: rtl/cic_rate_ctrl.sv
module cic_rate_ctrl
  import cic_pkg::*;
#(
  parameter int N_STAGES = 3,
  parameter int R_MIN    = 3,
  parameter int R_MAX    = 4096,
  parameter int RATIO_W  = 13,
  parameter int SH_W     = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               srst_i,
  input  logic               in_valid_i,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic [SH_W-1:0]    shift_o,
  output logic               boundary_o,
  output logic               reload_o,
  output logic               emit_o
);
  localparam logic [RATIO_W-1:0] RMIN_V = RATIO_W'(R_MIN);
  localparam logic [RATIO_W-1:0] RMAX_V = RATIO_W'(R_MAX);

  logic [RATIO_W-1:0] ratio_q, cnt_q, ratio_req;
  logic [SH_W-1:0]    shift_q;
  logic               change;

  always_comb begin
    if (ratio_i < RMIN_V)      ratio_req = RMIN_V;
    else if (ratio_i > RMAX_V) ratio_req = RMAX_V;
    else                       ratio_req = ratio_i;
  end

  assign boundary_o = in_valid_i && !srst_i && (cnt_q == ratio_q - 1'b1);
  assign change     = ratio_req != ratio_q;
  assign reload_o   = srst_i || (boundary_o && change);
  assign emit_o     = boundary_o && !change;
  assign shift_o    = shift_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ratio_q <= RMIN_V;
      shift_q <= SH_W'(gain_shift(R_MIN, N_STAGES));
      cnt_q   <= '0;
    end else if (reload_o) begin
      ratio_q <= ratio_req;
      shift_q <= SH_W'(gain_shift(int'(ratio_req), N_STAGES));
      cnt_q   <= '0;
    end else if (boundary_o) begin
      cnt_q <= '0;
    end else if (in_valid_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assert_ratio_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ratio_q >= RMIN_V) && (ratio_q <= RMAX_V));
  assert_count_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < ratio_q);
  assert_ratio_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ratio_q != $past(ratio_q)) |-> $past(srst_i || boundary_o));
endmodule

// File: rtl/cic_decimator.sv
module cic_decimator
  import cic_pkg::*;
#(
  parameter int N_STAGES = 3,
  parameter int IN_W     = 16,
  parameter int OUT_W    = 16,
  parameter int R_MIN    = 3,
  parameter int R_MAX    = 4096,
  localparam int RATIO_W = $clog2(R_MAX + 1),
  localparam int ACC_W   = IN_W + N_STAGES * $clog2(R_MAX),
  localparam int SH_W    = $clog2(N_STAGES * $clog2(R_MAX) + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    srst_i,
  input  logic [RATIO_W-1:0]      ratio_i,
  input  logic                    in_valid_i,
  input  logic signed [IN_W-1:0]  in_data_i,
  output logic                    out_valid_o,
  output logic signed [OUT_W-1:0] out_data_o
);
  logic [SH_W-1:0]         shift;
  logic                    boundary, reload, emit, clr;
  logic [ACC_W-1:0]        integ_out, comb_out;
  logic signed [ACC_W-1:0] scaled;

  cic_rate_ctrl #(
    .N_STAGES(N_STAGES), .R_MIN(R_MIN), .R_MAX(R_MAX),
    .RATIO_W(RATIO_W), .SH_W(SH_W)
  ) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .srst_i(srst_i), .in_valid_i(in_valid_i),
    .ratio_i(ratio_i), .shift_o(shift), .boundary_o(boundary),
    .reload_o(reload), .emit_o(emit)
  );

  assign clr = reload;

  cic_integrators #(.N_STAGES(N_STAGES), .IN_W(IN_W), .ACC_W(ACC_W)) u_integ (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr), .en_i(in_valid_i),
    .din_i(in_data_i), .dout_o(integ_out)
  );

  cic_combs #(.N_STAGES(N_STAGES), .ACC_W(ACC_W)) u_comb (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr), .en_i(emit),
    .din_i(integ_out), .dout_o(comb_out)
  );

  assign scaled = $signed(comb_out) >>> shift;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
    end else begin
      out_valid_o <= emit;
      if (emit) out_data_o <= scaled[OUT_W-1:0];
    end
  end

  assert_single_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |=> !out_valid_o);
  assert_valid_source_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $past(in_valid_i && !srst_i));
  assert_srst_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_i |=> !out_valid_o);
  assert_hold_data_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> $stable(out_data_o));
endmodule

// File: tb/tb_cic_decimator.sv
`timescale 1ns/1ps
module tb_cic_decimator;
  logic               clk_i = 1'b0;
  logic               rst_ni = 1'b0;
  logic               srst_i = 1'b0;
  logic [12:0]        ratio_i = 13'd3;
  logic               in_valid_i = 1'b0;
  logic signed [15:0] in_data_i = '0;
  logic               out_valid_o;
  logic signed [15:0] out_data_o;

  int checks = 0, fails = 0;
  bit finished = 1'b0;
  string req = "R8";

  // behavioural reference: triple running sums, decimated triple difference
  longint s1, s2, s3, d1, d2, d3;
  int     m_ratio, m_shift, m_cnt;
  bit     e_valid;
  logic signed [15:0] e_data;

  always #4 clk_i = ~clk_i;

  cic_decimator dut (.*);

  function automatic int clampr(int r);
    return (r < 3) ? 3 : ((r > 4096) ? 4096 : r);
  endfunction

  function automatic int shift_for(int r);
    longint g = longint'(r) * r * r;
    int s = 0;
    while ((64'sd1 <<< s) < g) s++;
    return s;
  endfunction

  task automatic model_clear();
    s1 = 0; s2 = 0; s3 = 0; d1 = 0; d2 = 0; d3 = 0; m_cnt = 0;
  endtask

  task automatic model_step();
    longint c1, c2, c3, y;
    int rq = clampr(int'(ratio_i));
    e_valid = 1'b0;
    if (srst_i) begin
      m_ratio = rq; m_shift = shift_for(rq); model_clear();
    end else if (in_valid_i) begin
      s1 += longint'(in_data_i); s2 += s1; s3 += s2;
      if (m_cnt == m_ratio - 1) begin
        if (rq != m_ratio) begin
          m_ratio = rq; m_shift = shift_for(rq); model_clear();
        end else begin
          c1 = s3 - d1; d1 = s3;
          c2 = c1 - d2; d2 = c1;
          c3 = c2 - d3; d3 = c2;
          y = c3 >>> m_shift;
          e_data = y[15:0];
          e_valid = 1'b1;
          m_cnt = 0;
        end
      end else m_cnt++;
    end
  endtask

  task automatic check();
    checks++;
    if (out_valid_o !== e_valid || out_data_o !== e_data) begin
      fails++;
      $display("FAIL %s t=%0t valid=%0b data=%0d expected valid=%0b data=%0d",
               req, $time, out_valid_o, out_data_o, e_valid, e_data);
    end
  endtask

  // one clock: drive at negedge, model at posedge, compare at next negedge
  task automatic cyc(bit v, logic signed [15:0] x, bit sr = 1'b0);
    in_valid_i = v; in_data_i = x; srst_i = sr;
    @(posedge clk_i);
    model_step();
    @(negedge clk_i);
    check();
  endtask

  task automatic run(int n, int kind, int gap = 0);
    for (int i = 0; i < n; i++) begin
      logic signed [15:0] x;
      case (kind)
        0: x = 16'sd1000;
        1: x = 16'(i * 37 - 500);
        2: x = (i % 2) ? 16'sd20000 : -16'sd20000;
        3: x = 16'sd32767;
        4: x = -16'sd32768;
        default: x = 16'($urandom);
      endcase
      cyc((gap == 0) || (i % gap != 0), x);
    end
  endtask

  task automatic load(int r);
    ratio_i = 13'(r);
    cyc(1'b1, 16'sd1234, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    m_ratio = 3; m_shift = shift_for(3); model_clear();
    e_valid = 1'b0; e_data = '0;
    repeat (3) @(negedge clk_i);
    req = "R8"; check();                     // reset state
    rst_ni = 1'b1;
    @(negedge clk_i);
    req = "R7"; load(5);                     // sample in srst cycle dropped
    req = "R3"; run(60, 0);                  // DC: 125*1000>>7
    req = "R1"; run(80, 1);                  // ramp
    req = "R9"; run(90, 5, 3);               // gaps in valid
    req = "R4"; run(50, 2);
    req = "R5"; load(2);  run(40, 5);        // clamps to 3, shift 5
    req = "R5"; load(0);  run(30, 2);
    req = "R9"; ratio_i = 13'd7; run(2, 0);  // mid-period change, no effect yet
    req = "R6"; run(10, 0);                  // boundary with change: drop, clear
    req = "R6"; run(40, 1);                  // now at R=7
    req = "R4"; load(4096); run(3*4096 + 20, 3);   // +full scale
    req = "R4"; load(4096); run(3*4096 + 20, 4);   // -full scale
    req = "R5"; load(5000); run(2*4096 + 10, 5);   // clamp to 4096
    req = "R2"; load(3);  run(30, 5);
    req = "R1"; load(64); run(64*6, 3);      // large sums
    req = "R7"; cyc(1'b1, 16'sd100, 1'b1); run(10, 0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule